// File: doc/BRIEF.md
# Hardwired Major-State Instruction Sequencer

This block is the control unit of a 16-bit two-operand processor. It has no microcode. A fixed state machine steps each instruction through up to five major phases: fetch, source operand, destination operand, execute and service. Inside each phase it runs a short chain of minor steps. A minor step is either an internal datapath action that lasts one cycle, or a bus cycle that waits for the bus interface to report completion.

The sequencer decodes the latched instruction word and skips phases that the instruction does not need. It picks a chain of steps for each operand addressing mode. It also picks the bus cycle type. A destination that will be written back is read with a read-pause cycle. The later write reuses the bus address already held, so no address is recomputed.

The sequencer drives a phase code, a step code, a bus request with its cycle type, a register select, a byte flag and two pulses to the datapath and bus blocks around it. The arithmetic, the register storage and the bus signalling all live outside this block.

Top module: `major_seq`

## Requirements
- R1: While rst_ni is low and on the first cycle after reset, major_o is 0 (fetch), minor_o is 0 (instruction read), bus_req_o is 1, bus_cyc_o is 0, and ld_ir_o and retire_o are 0.
- R2: A bus step (minor codes 0, 4, 6, 7, 9, 10) holds major_o, minor_o and bus_cyc_o unchanged until a cycle with bus_done_i high, and advances on the next edge. An internal step (minor codes 1, 2, 3, 5, 8, 11) lasts exactly one cycle.
- R3: The instruction class is ir[14:12]. Class 000 has one operand, class 111 has none, and every other class has two operands. The source phase (major code 1) is entered only for two-operand classes whose source mode ir[11:9] is nonzero. After decode (minor 1), control goes to the source phase, else to the destination phase, else to execute.
- R4: The destination phase (major code 2) is skipped when the destination mode ir[5:3] is 0 or the class is 111.
- R5: Each operand phase runs these steps by mode. Mode 1: address (2), operand read (7). Mode 2: address, step (3), read. Mode 3: address, step, indirect read (6), read. Mode 4: step, address, read. Mode 5: step, address, indirect, read. Mode 6: index read (4), sum (5), read. Mode 7: index, sum, indirect, read.
- R6: bus_cyc_o codes are 0 read, 1 read-pause and 2 write that reuses the address. The destination operand read uses code 1 when a memory write-back follows, and code 0 otherwise. Index, indirect and source reads always use code 0.
- R7: Execute (major code 3) runs one ALU step (8). It then runs a write step (9) with bus_cyc_o = 2 exactly when the destination phase ran and the class is not 010 (the compare class, which never writes back).
- R8: If svc_req_i is high in the cycle that execute completes, the service phase follows (major 4): a vector read (10), then a PC load (11), then fetch. Otherwise fetch follows at once.
- R9: ld_ir_o is high in the cycle the instruction read completes, and ir_i is captured then. retire_o is high in the cycle the last execute step completes.
- R10: bus_req_o is high exactly during bus steps. bus_cyc_o is 0 during internal steps.
- R11: After decode, reg_sel_o shows ir[8:6] during the source phase and ir[2:0] in every other phase. byte_o shows ir[15] of the latched instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_done_i | input | 1 | Bus interface reports that the current bus step is complete |
| svc_req_i | input | 1 | Interrupt or trap pending |
| ir_i | input | 16 | Instruction word, captured when the instruction read completes |
| major_o | output | 3 | Major phase: 0 fetch, 1 source, 2 destination, 3 execute, 4 service |
| minor_o | output | 4 | Current minor step code |
| bus_req_o | output | 1 | A bus step is active |
| bus_cyc_o | output | 2 | Bus cycle type: 0 read, 1 read-pause, 2 write reusing the address |
| reg_sel_o | output | 3 | Register number for the datapath |
| byte_o | output | 1 | Byte-width flag of the latched instruction |
| ld_ir_o | output | 1 | Instruction register load strobe |
| retire_o | output | 1 | Instruction completes this cycle |

## Verification
Two events can fall in the same cycle: an instruction's retirement and the decision to take a pending service request. The retirement cycle is either the one-cycle ALU step or the final cycle of a write-back bus step, where bus_done_i is high. The bench holds svc_req_i high for a spread of instructions drawn from every class and every pair of operand modes, so both endings meet a pending request. It judges the outcome by whether the very next step is a vector read or an instruction read. It also varies the bus wait states, so that the completing edge moves relative to the request.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int IW     = 16;
  localparam int MODE_W = 3;
  localparam int REG_W  = 3;
  localparam int CLS_W  = 3;
  localparam int POS_W  = 3;
  localparam int DREG_LO = 0;
  localparam int DMOD_LO = DREG_LO + REG_W;
  localparam int SREG_LO = DMOD_LO + MODE_W;
  localparam int SMOD_LO = SREG_LO + REG_W;
  localparam int CLS_LO  = SMOD_LO + MODE_W;
  localparam int BYTE_B  = CLS_LO + CLS_W;

  localparam logic [CLS_W-1:0] CLS_ONE  = 3'b000;
  localparam logic [CLS_W-1:0] CLS_NONE = 3'b111;
  localparam logic [CLS_W-1:0] CLS_CMP  = 3'b010;

  typedef enum logic [2:0] {
    PH_FETCH = 3'd0, PH_SRC = 3'd1, PH_DST = 3'd2, PH_EXE = 3'd3, PH_SVC = 3'd4
  } major_e;

  typedef enum logic [3:0] {
    ST_IRD   = 4'd0,  ST_DEC  = 4'd1,  ST_ADDR = 4'd2,  ST_STEP = 4'd3,
    ST_IDX   = 4'd4,  ST_SUM  = 4'd5,  ST_IND  = 4'd6,  ST_OPR  = 4'd7,
    ST_ALU   = 4'd8,  ST_WR   = 4'd9,  ST_VEC  = 4'd10, ST_LDPC = 4'd11
  } minor_e;

  typedef enum logic [1:0] {
    CY_RD = 2'd0, CY_RDP = 2'd1, CY_WRA = 2'd2
  } cyc_e;

  function automatic logic is_bus(minor_e s);
    return (s == ST_IRD) || (s == ST_IDX) || (s == ST_IND) ||
           (s == ST_OPR) || (s == ST_WR)  || (s == ST_VEC);
  endfunction
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  logic [IW-1:0]     ir_i,
  output logic [MODE_W-1:0] src_mode_o,
  output logic [MODE_W-1:0] dst_mode_o,
  output logic [REG_W-1:0]  src_reg_o,
  output logic [REG_W-1:0]  dst_reg_o,
  output logic              byte_o,
  output logic              use_src_o,
  output logic              use_dst_o,
  output logic              wb_mem_o
);
  logic [CLS_W-1:0] cls;
  logic             two_op;

  always_comb begin
    cls        = ir_i[CLS_LO +: CLS_W];
    src_mode_o = ir_i[SMOD_LO +: MODE_W];
    dst_mode_o = ir_i[DMOD_LO +: MODE_W];
    src_reg_o  = ir_i[SREG_LO +: REG_W];
    dst_reg_o  = ir_i[DREG_LO +: REG_W];
    byte_o     = ir_i[BYTE_B];
    two_op     = (cls != CLS_ONE) && (cls != CLS_NONE);
    use_src_o  = two_op && (src_mode_o != '0);
    use_dst_o  = (cls != CLS_NONE) && (dst_mode_o != '0);
    wb_mem_o   = use_dst_o && (cls != CLS_CMP);
  end
endmodule

// File: rtl/seq_opnd.sv
module seq_opnd
  import seq_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic [POS_W-1:0]  pos_i,
  output minor_e            step_o,
  output logic              last_o
);
  always_comb begin
    step_o = ST_OPR;
    unique case (mode_i)
      3'd1: step_o = (pos_i == 0) ? ST_ADDR : ST_OPR;
      3'd2: step_o = (pos_i == 0) ? ST_ADDR :
                     (pos_i == 1) ? ST_STEP : ST_OPR;
      3'd3: step_o = (pos_i == 0) ? ST_ADDR :
                     (pos_i == 1) ? ST_STEP :
                     (pos_i == 2) ? ST_IND  : ST_OPR;
      3'd4: step_o = (pos_i == 0) ? ST_STEP :
                     (pos_i == 1) ? ST_ADDR : ST_OPR;
      3'd5: step_o = (pos_i == 0) ? ST_STEP :
                     (pos_i == 1) ? ST_ADDR :
                     (pos_i == 2) ? ST_IND  : ST_OPR;
      3'd6: step_o = (pos_i == 0) ? ST_IDX  :
                     (pos_i == 1) ? ST_SUM  : ST_OPR;
      3'd7: step_o = (pos_i == 0) ? ST_IDX  :
                     (pos_i == 1) ? ST_SUM  :
                     (pos_i == 2) ? ST_IND  : ST_OPR;
      default: step_o = ST_OPR;
    endcase
    last_o = (step_o == ST_OPR);
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_done_i,
  input  logic             svc_req_i,
  input  logic [IW-1:0]    ir_i,
  input  logic             use_src_i,
  input  logic             use_dst_i,
  input  logic             wb_mem_i,
  input  minor_e           src_step_i,
  input  logic             src_last_i,
  input  minor_e           dst_step_i,
  input  logic             dst_last_i,
  output major_e           major_o,
  output minor_e           minor_o,
  output logic [POS_W-1:0] pos_o,
  output logic [IW-1:0]    ir_q_o,
  output logic             bus_req_o,
  output cyc_e             cyc_o,
  output logic             ld_ir_o,
  output logic             retire_o
);
  major_e           major_q, major_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [IW-1:0]    ir_q;
  logic             adv;

  always_comb begin
    major_d  = major_q;
    pos_d    = pos_q;
    minor_o  = ST_IRD;
    cyc_o    = CY_RD;
    ld_ir_o  = 1'b0;
    retire_o = 1'b0;
    unique case (major_q)
      PH_FETCH: minor_o = (pos_q == 0) ? ST_IRD : ST_DEC;
      PH_SRC:   minor_o = src_step_i;
      PH_DST:   minor_o = dst_step_i;
      PH_EXE:   minor_o = (pos_q == 0) ? ST_ALU : ST_WR;
      PH_SVC:   minor_o = (pos_q == 0) ? ST_VEC : ST_LDPC;
      default:  minor_o = ST_IRD;
    endcase
    bus_req_o = is_bus(minor_o);
    adv       = !bus_req_o || bus_done_i;
    if (minor_o == ST_WR) cyc_o = CY_WRA;
    else if (minor_o == ST_OPR && major_q == PH_DST && wb_mem_i) cyc_o = CY_RDP;
    if (adv) begin
      unique case (major_q)
        PH_FETCH: begin
          if (pos_q == 0) begin
            ld_ir_o = 1'b1;
            pos_d   = 1;
          end else begin
            pos_d   = '0;
            major_d = use_src_i ? PH_SRC : use_dst_i ? PH_DST : PH_EXE;
          end
        end
        PH_SRC: begin
          if (src_last_i) begin
            pos_d   = '0;
            major_d = use_dst_i ? PH_DST : PH_EXE;
          end else pos_d = pos_q + 1'b1;
        end
        PH_DST: begin
          if (dst_last_i) begin
            pos_d   = '0;
            major_d = PH_EXE;
          end else pos_d = pos_q + 1'b1;
        end
        PH_EXE: begin
          if (pos_q == 0 && wb_mem_i) pos_d = 1;
          else begin
            retire_o = 1'b1;
            pos_d    = '0;
            major_d  = svc_req_i ? PH_SVC : PH_FETCH;
          end
        end
        PH_SVC: begin
          if (pos_q == 0) pos_d = 1;
          else begin
            pos_d   = '0;
            major_d = PH_FETCH;
          end
        end
        default: begin
          pos_d   = '0;
          major_d = PH_FETCH;
        end
      endcase
    end
    if (!adv || !bus_req_o) cyc_o = bus_req_o ? cyc_o : CY_RD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      major_q <= PH_FETCH;
      pos_q   <= '0;
      ir_q    <= '0;
    end else begin
      major_q <= major_d;
      pos_q   <= pos_d;
      if (ld_ir_o) ir_q <= ir_i;
    end
  end

  assign major_o = major_q;
  assign pos_o   = pos_q;
  assign ir_q_o  = ir_q;
endmodule

// File: rtl/major_seq.sv
module major_seq
  import seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_done_i,
  input  logic              svc_req_i,
  input  logic [IW-1:0]     ir_i,
  output logic [2:0]        major_o,
  output logic [3:0]        minor_o,
  output logic              bus_req_o,
  output logic [1:0]        bus_cyc_o,
  output logic [REG_W-1:0]  reg_sel_o,
  output logic              byte_o,
  output logic              ld_ir_o,
  output logic              retire_o
);
  localparam int NOPND = 2;

  logic [IW-1:0]     ir_q;
  logic [MODE_W-1:0] src_mode, dst_mode;
  logic [REG_W-1:0]  src_reg, dst_reg;
  logic              use_src, use_dst, wb_mem;
  logic [POS_W-1:0]  pos;
  major_e            major;
  minor_e            minor;
  cyc_e              cyc;
  logic [MODE_W-1:0] op_mode [NOPND];
  minor_e            op_step [NOPND];
  logic              op_last [NOPND];

  seq_decode i_dec (
    .ir_i       (ir_q),
    .src_mode_o (src_mode),
    .dst_mode_o (dst_mode),
    .src_reg_o  (src_reg),
    .dst_reg_o  (dst_reg),
    .byte_o     (byte_o),
    .use_src_o  (use_src),
    .use_dst_o  (use_dst),
    .wb_mem_o   (wb_mem)
  );

  assign op_mode[0] = src_mode;
  assign op_mode[1] = dst_mode;

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    seq_opnd i_opnd (
      .mode_i (op_mode[g]),
      .pos_i  (pos),
      .step_o (op_step[g]),
      .last_o (op_last[g])
    );
  end

  seq_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_done_i (bus_done_i),
    .svc_req_i  (svc_req_i),
    .ir_i       (ir_i),
    .use_src_i  (use_src),
    .use_dst_i  (use_dst),
    .wb_mem_i   (wb_mem),
    .src_step_i (op_step[0]),
    .src_last_i (op_last[0]),
    .dst_step_i (op_step[1]),
    .dst_last_i (op_last[1]),
    .major_o    (major),
    .minor_o    (minor),
    .pos_o      (pos),
    .ir_q_o     (ir_q),
    .bus_req_o  (bus_req_o),
    .cyc_o      (cyc),
    .ld_ir_o    (ld_ir_o),
    .retire_o   (retire_o)
  );

  assign major_o   = major;
  assign minor_o   = minor;
  assign bus_cyc_o = cyc;
  assign reg_sel_o = (major == PH_SRC) ? src_reg : dst_reg;
endmodule

// File: rtl/major_seq_chk.sv
module major_seq_chk
  import seq_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_done_i,
  input logic          svc_req_i,
  input logic [2:0]    major_o,
  input logic [3:0]    minor_o,
  input logic          bus_req_o,
  input logic [1:0]    bus_cyc_o,
  input logic          ld_ir_o,
  input logic          retire_o,
  input logic [IW-1:0] ir_q
);
  logic [CLS_W-1:0]  cls;
  logic [MODE_W-1:0] smode, dmode;
  assign cls   = ir_q[CLS_LO +: CLS_W];
  assign smode = ir_q[SMOD_LO +: MODE_W];
  assign dmode = ir_q[DMOD_LO +: MODE_W];

  p_bus_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_done_i) |=> ($stable(major_o) && $stable(minor_o) && $stable(bus_cyc_o)));

  p_src_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (major_o == 3'd1) |-> (smode != 0 && cls != CLS_ONE && cls != CLS_NONE));

  p_dst_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (major_o == 3'd2) |-> (dmode != 0 && cls != CLS_NONE));

  p_rdpause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_cyc_o == 2'd1) |-> (major_o == 3'd2 && minor_o == 4'd7 && cls != CLS_CMP));

  p_write_reuse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_cyc_o == 2'd2) |-> (major_o == 3'd3 && dmode != 0 && cls != CLS_CMP));

  p_svc_take_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_o && svc_req_i) |=> (major_o == 3'd4 && minor_o == 4'd10));

  p_svc_skip_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_o && !svc_req_i) |=> (major_o == 3'd0 && minor_o == 4'd0));

  p_ir_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ir_o |=> (minor_o == 4'd1));
endmodule

bind major_seq major_seq_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_done_i (bus_done_i),
  .svc_req_i  (svc_req_i),
  .major_o    (major_o),
  .minor_o    (minor_o),
  .bus_req_o  (bus_req_o),
  .bus_cyc_o  (bus_cyc_o),
  .ld_ir_o    (ld_ir_o),
  .retire_o   (retire_o),
  .ir_q       (ir_q)
);

// File: tb/test_major_seq.sv
module test_major_seq;
  localparam int CLK_PERIOD = 10;
  localparam int MAXS = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_done_i = 1'b0;
  logic        svc_req_i = 1'b0;
  logic [15:0] ir_i = '0;
  logic [2:0]  major_o;
  logic [3:0]  minor_o;
  logic        bus_req_o;
  logic [1:0]  bus_cyc_o;
  logic [2:0]  reg_sel_o;
  logic        byte_o;
  logic        ld_ir_o;
  logic        retire_o;

  int total = 0;
  int bad = 0;

  int    e_maj [MAXS];
  int    e_min [MAXS];
  int    e_bus [MAXS];
  int    e_cyc [MAXS];
  string e_tag [MAXS];
  int    n_st;
  int    ret_idx;

  major_seq i_major_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_done_i(bus_done_i), .svc_req_i(svc_req_i),
    .ir_i(ir_i), .major_o(major_o), .minor_o(minor_o), .bus_req_o(bus_req_o),
    .bus_cyc_o(bus_cyc_o), .reg_sel_o(reg_sel_o), .byte_o(byte_o),
    .ld_ir_o(ld_ir_o), .retire_o(retire_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic add(input int maj, input int mn, input int bus, input int cyc, input string tag);
    e_maj[n_st] = maj; e_min[n_st] = mn; e_bus[n_st] = bus;
    e_cyc[n_st] = cyc; e_tag[n_st] = tag;
    n_st++;
  endtask

  // R5 step lists, R6 cycle type on the destination operand read
  task automatic opnd(input int maj, input int mode, input bit wb);
    int rd = (maj == 2 && wb) ? 1 : 0;
    case (mode)
      1: begin add(maj,2,0,0,"R5"); end
      2: begin add(maj,2,0,0,"R5"); add(maj,3,0,0,"R5"); end
      3: begin add(maj,2,0,0,"R5"); add(maj,3,0,0,"R5"); add(maj,6,1,0,"R5"); end
      4: begin add(maj,3,0,0,"R5"); add(maj,2,0,0,"R5"); end
      5: begin add(maj,3,0,0,"R5"); add(maj,2,0,0,"R5"); add(maj,6,1,0,"R5"); end
      6: begin add(maj,4,1,0,"R5"); add(maj,5,0,0,"R5"); end
      7: begin add(maj,4,1,0,"R5"); add(maj,5,0,0,"R5"); add(maj,6,1,0,"R5"); end
      default: ;
    endcase
    add(maj, 7, 1, rd, "R6");
  endtask

  task automatic build(input logic [15:0] ir, input bit svc);
    int  cls = ir[14:12];
    int  sm  = ir[11:9];
    int  dm  = ir[5:3];
    bit  two = (cls != 0) && (cls != 7);
    bit  us  = two && (sm != 0);
    bit  ud  = (cls != 7) && (dm != 0);
    bit  wb  = ud && (cls != 2);
    n_st = 0;
    add(0, 0, 1, 0, "R9");
    add(0, 1, 0, 0, "R3");
    if (us) opnd(1, sm, wb);
    if (ud) opnd(2, dm, wb);
    add(3, 8, 0, 0, "R4");
    if (wb) add(3, 9, 1, 2, "R7");
    ret_idx = n_st - 1;
    if (svc) begin
      add(4, 10, 1, 0, "R8");
      add(4, 11, 0, 0, "R8");
    end
  endtask

  task automatic run_instr(input logic [15:0] ir, input int wn, input bit svc);
    build(ir, svc);
    svc_req_i = svc;
    for (int k = 0; k < n_st; k++) begin
      logic [9:0] exp_obs = {e_maj[k][2:0], e_min[k][3:0], e_bus[k][0], e_cyc[k][1:0]};
      logic [9:0] obs = {major_o, minor_o, bus_req_o, bus_cyc_o};
      chk(obs == exp_obs, {e_tag[k], " R10 step"}, obs, exp_obs);
      if (k >= 1) begin
        logic [2:0] es = (e_maj[k] == 1) ? ir[8:6] : ir[2:0];
        chk(reg_sel_o == es, "R11 reg_sel", reg_sel_o, es);
        chk(byte_o == ir[15], "R11 byte", byte_o, ir[15]);
      end
      if (e_bus[k] != 0) begin
        for (int w = 0; w < wn; w++) begin
          bus_done_i = 1'b0;
          @(posedge clk_i); @(negedge clk_i);
          obs = {major_o, minor_o, bus_req_o, bus_cyc_o};
          chk(obs == exp_obs, "R2 hold", obs, exp_obs);
        end
        bus_done_i = 1'b1;
        if (e_min[k] == 0) ir_i = ir;
      end
      #1;
      chk(ld_ir_o == (e_min[k] == 0), "R9 ld_ir", ld_ir_o, e_min[k] == 0);
      chk(retire_o == (k == ret_idx), "R9 retire", retire_o, k == ret_idx);
      @(posedge clk_i); @(negedge clk_i);
      bus_done_i = 1'b0;
      ir_i = 16'hxxxx;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    $display("FAIL R2 watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int idx = 0;
    int clsl [4] = '{0, 1, 2, 7};
    repeat (2) @(negedge clk_i);
    // R1 reset state
    chk({major_o, minor_o, bus_req_o, bus_cyc_o} == {3'd0, 4'd0, 1'b1, 2'd0},
        "R1 reset outputs", {major_o, minor_o, bus_req_o, bus_cyc_o}, 10'h004);
    chk(ld_ir_o == 1'b0 && retire_o == 1'b0, "R1 reset pulses", {ld_ir_o, retire_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({major_o, minor_o, bus_req_o} == {3'd0, 4'd0, 1'b1}, "R1 after reset",
        {major_o, minor_o, bus_req_o}, 8'h01);
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < 8; s++) begin
        for (int d = 0; d < 8; d++) begin
          logic [15:0] ir;
          ir = {idx[0], clsl[c][2:0], s[2:0], idx[3:1], d[2:0], idx[6:4]};
          run_instr(ir, idx % 3, (idx % 5) == 2 || (idx % 7) == 3);
          idx++;
        end
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule